// File: doc/BRIEF.md
# Handshaked Holding-Register Word Crossing

This block carries one multi-bit word from a source clock domain to an unrelated destination clock domain. It does not synchronize the data bits. The source side writes the word into a holding register when it accepts a load strobe, and in the same cycle it raises a request line. The destination captures the register contents once its synchronized copy of the request is high, then raises an acknowledge line. The two control lines follow a four-phase sequence: request up, acknowledge up, request down, acknowledge down. The holding register cannot change while this sequence runs, so the destination always samples a settled bus.

On the source side, `src_busy` tells the producer that a word is in flight. The producer may present a new word only when busy is low, and a strobe while busy is dropped. On the destination side, each received word appears on `dst_data` with a single-cycle `dst_valid` pulse. Each control line leaves a flop in its own domain and passes through a chain of `SYNC_STAGES` flops with no logic in between. Each domain has its own active-low reset.

Source state machine, states and transitions:
- SRC_IDLE goes to SRC_REQ on an accepted strobe.
- SRC_REQ goes to SRC_DRAIN when the synchronized acknowledge is high.
- SRC_DRAIN goes to SRC_IDLE when the synchronized acknowledge is low.

Destination state machine, states and transitions:
- DST_WAIT goes to DST_ACK when the synchronized request is high. The word is captured on this transition.
- DST_ACK goes to DST_WAIT when the synchronized request is low.

Top module: `hs_bus_crossing`

## Requirements
- R1: After reset, `src_busy` is 0, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A `src_load` sampled high while `src_busy` is low is accepted: `src_data` is written to the holding register, request rises at the same edge, and `src_busy` reads 1 from the next source cycle.
- R3: A `src_load` sampled while `src_busy` is high is ignored: its word is never delivered and the word in flight is not disturbed.
- R4: The holding register does not change while the source is busy, so changes on `src_data` after acceptance have no effect on the delivered word.
- R5: Four-phase order: request rises only while the synchronized acknowledge is low, and falls only after the synchronized acknowledge was high. Acknowledge rises only after the synchronized request was high, and falls only after the synchronized request was low.
- R6: Every accepted word appears on `dst_data` exactly once and in acceptance order. `dst_valid` is high for exactly one destination cycle per word, and `dst_data` holds its value between pulses.
- R7: `src_busy` stays high until the word has been handed over and the acknowledge has been seen low again. After that it returns to 0 within a bounded time.
- R8: Request and acknowledge each pass through `SYNC_STAGES` (default 2) flops. As a result, `dst_valid` rises no earlier than 2 and no later than 4 destination periods after the accepting source edge.
- R9: The resets are independent. Resetting only the destination clears `dst_data`/`dst_valid` and leaves `src_busy` low. Resetting only the source leaves `dst_data` unchanged. Transfers work again after either reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain active-low reset |
| src_load | input | 1 | Strobe to accept `src_data` |
| src_data | input | DATA_W | Word to send |
| src_busy | output | 1 | High while a word is in flight |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain active-low reset |
| dst_data | output | DATA_W | Last received word |
| dst_valid | output | 1 | One-cycle pulse when `dst_data` updates |

## Verification
The bench covers four main cases, each tied to a specific failure:
- **Source data changes after acceptance.** The bench scrambles `src_data` on every cycle while the source is busy. A design that kept writing the holding register would deliver a torn or later word.
- **Load held high continuously.** A design that accepted strobes while busy would deliver extra words. A design that released busy before the acknowledge returned low would start a request the destination cannot see as new, and that word would be lost.
- **Slow and fast destination clocks.** Both a destination slower than the source and one faster than it are run. Here the latency window catches a missing synchronizer stage, and the pulse check catches a valid signal that follows the level of the request.
- **Separate resets.** Each domain is reset on its own to show that neither disturbs the other's state.

// File: rtl/bxh_pkg.sv
package bxh_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_REQ   = 2'd1,
        SRC_DRAIN = 2'd2
    } src_state_e;

    typedef enum logic {
        DST_WAIT = 1'b0,
        DST_ACK  = 1'b1
    } dst_state_e;

endpackage

// File: rtl/bxh_sync.sv
// Flop chain for one asynchronous control line; no logic between stages.
module bxh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_async};
    end

    assign q_sync = chain_q[LAST];
endmodule

// File: rtl/bxh_src.sv
// Source side: accepts a word, holds it, drives request from a flop.
module bxh_src
    import bxh_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ack_async,
    output logic              busy,
    output logic              req_out,
    output logic [DATA_W-1:0] hold_out
);
    src_state_e        st_q, st_d;
    logic              ack_s;
    logic              req_q;
    logic [DATA_W-1:0] hold_q;
    logic              take;

    bxh_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ack_async),
        .q_sync (ack_s)
    );

    assign take = (st_q == SRC_IDLE) && load;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SRC_IDLE:  if (load)   st_d = SRC_REQ;
            SRC_REQ:   if (ack_s)  st_d = SRC_DRAIN;
            SRC_DRAIN: if (!ack_s) st_d = SRC_IDLE;
            default:               st_d = SRC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_IDLE;
        else        st_q <= st_d;
    end

    // Registered outputs: request and holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            req_q <= (st_d == SRC_REQ);
            if (take) hold_q <= data_in;
        end
    end

    assign busy     = (st_q != SRC_IDLE);
    assign req_out  = req_q;
    assign hold_out = hold_q;

    // R4: holding register frozen while a transfer is in flight
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SRC_IDLE) |=> $stable(hold_q));

    // R5: request only rises while acknowledge is seen low
    p_req_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !$past(ack_s));

    // R5: request only falls after acknowledge was seen high
    p_req_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_s));

    // R7: busy covers the whole time request is high
    p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> busy);
endmodule

// File: rtl/bxh_dst.sv
// Destination side: captures the held word on synchronized request.
module bxh_dst
    import bxh_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] hold_in,
    output logic              ack_out,
    output logic [DATA_W-1:0] data_out,
    output logic              valid_out
);
    dst_state_e        st_q, st_d;
    logic              req_s;
    logic              ack_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              grab;

    bxh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(req_async),
        .q_sync (req_s)
    );

    assign grab = (st_q == DST_WAIT) && req_s;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DST_WAIT: if (req_s)  st_d = DST_ACK;
            DST_ACK:  if (!req_s) st_d = DST_WAIT;
            default:              st_d = DST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DST_WAIT;
        else        st_q <= st_d;
    end

    // Registered outputs: acknowledge, captured word, valid pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            ack_q   <= (st_d == DST_ACK);
            valid_q <= grab;
            if (grab) data_q <= hold_in;
        end
    end

    assign ack_out   = ack_q;
    assign data_out  = data_q;
    assign valid_out = valid_q;

    // R5: acknowledge rises only after request was seen high
    p_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(req_s));

    // R5: acknowledge falls only after request was seen low
    p_ack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(req_s));

    // R6: valid is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6: output word only changes together with valid
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q));
endmodule

// File: rtl/hs_bus_crossing.sv
module hs_bus_crossing #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_load,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_valid
);
    logic              req_line;
    logic              ack_line;
    logic [DATA_W-1:0] hold_bus;

    bxh_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .load     (src_load),
        .data_in  (src_data),
        .ack_async(ack_line),
        .busy     (src_busy),
        .req_out  (req_line),
        .hold_out (hold_bus)
    );

    bxh_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_async(req_line),
        .hold_in  (hold_bus),
        .ack_out  (ack_line),
        .data_out (dst_data),
        .valid_out(dst_valid)
    );
endmodule

// File: tb/test_hs_bus_crossing.sv
module test_hs_bus_crossing;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int BUSY_LIMIT = 80;
    localparam int WATCHDOG   = 150000;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    int            dst_half = 17;
    logic          src_rst_n, dst_rst_n, src_load, src_busy, dst_valid;
    logic [DW-1:0] src_data, dst_data;

    always #(CLK_PERIOD/2) src_clk = ~src_clk;
    always begin #(dst_half) dst_clk = ~dst_clk; end

    hs_bus_crossing #(.DATA_W(DW), .SYNC_STAGES(2)) i_hs_bus_crossing (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
        .src_data(src_data), .src_busy(src_busy),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_data(dst_data), .dst_valid(dst_valid)
    );

    int            checks = 0, fails = 0, ignored = 0, busy_cnt = 0, cyc = 0;
    bit            run = 0, acc_prev = 0, outstanding = 0, delivered = 0, prev_valid = 0;
    logic [DW-1:0] exp_q[$];
    time           t_q[$];
    logic [DW-1:0] last_data = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge src_clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    // Source-side reference: acceptance and busy expectations
    always @(negedge src_clk) begin
        if (!src_rst_n) begin
            acc_prev = 0; outstanding = 0; busy_cnt = 0;
        end else if (run) begin
            if (acc_prev) check(src_busy, "R2", "busy after accepted load", DW'(src_busy), DW'(1));
            if (outstanding && !delivered)
                check(src_busy, "R7", "busy held until handover", DW'(src_busy), DW'(1));
            if (outstanding && !src_busy) outstanding = 0;
            if (src_busy) busy_cnt++; else busy_cnt = 0;
            if (busy_cnt == BUSY_LIMIT) check(1'b0, "R7", "busy released in time", DW'(busy_cnt), DW'(0));
            acc_prev = 0;
            if (src_load) begin
                if (!src_busy) begin
                    exp_q.push_back(src_data);
                    t_q.push_back($time + CLK_PERIOD/2);
                    outstanding = 1; delivered = 0; acc_prev = 1;
                end else ignored++;
            end
        end
    end

    // Destination-side reference: words in order, pulses, latency window
    always @(negedge dst_clk) begin
        if (!dst_rst_n) begin
            prev_valid = 0; last_data = '0;
        end else if (run) begin
            if (dst_valid) begin
                if (prev_valid) check(1'b0, "R6", "valid wider than one cycle", DW'(1), DW'(0));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "word delivered that was never accepted", dst_data, '0);
                end else begin
                    time el;
                    el = $time - t_q[0];
                    check(dst_data == exp_q[0], "R6", "delivered word", dst_data, exp_q[0]);
                    check(el >= 4*dst_half && el <= 8*dst_half, "R8", "capture latency",
                          DW'(el), DW'(8*dst_half));
                    void'(exp_q.pop_front());
                    void'(t_q.pop_front());
                    delivered = 1;
                end
            end else begin
                check(dst_data == last_data, "R6", "data held between pulses", dst_data, last_data);
            end
            prev_valid = dst_valid;
            last_data  = dst_data;
        end
    end

    task automatic drive(input logic l, input logic [DW-1:0] d);
        @(posedge src_clk); #2;
        src_load = l; src_data = d;
    endtask

    task automatic wait_idle;
        @(negedge src_clk);
        while (src_busy) @(negedge src_clk);
        repeat (3) @(negedge src_clk);
    endtask

    task automatic send(input logic [DW-1:0] d);
        wait_idle();
        drive(1'b1, d);
        drive(1'b0, d);
    endtask

    task automatic pattern_set;
        send(16'hA5C3);
        send(16'hFFFF);
        send(16'h0001);
        send(16'h8000);
        // R4: scramble source data while the word is in flight
        wait_idle();
        drive(1'b1, 16'h1234);
        for (int i = 0; i < 40; i++) drive(1'b0, DW'(i * 16'h0F1D) ^ 16'hC0DE);
        wait_idle();
        // R3: strobe held high; only strobes seen while idle count
        for (int i = 0; i < 120; i++) drive(1'b1, DW'(i * 16'h0101) ^ 16'h5A5A);
        drive(1'b0, '0);
        wait_idle();
    endtask

    initial begin
        logic [DW-1:0] kept;
        src_rst_n = 1'b0; dst_rst_n = 1'b0; src_load = 1'b0; src_data = '0;
        repeat (3) @(posedge src_clk);
        #2 src_rst_n = 1'b1;
        @(posedge dst_clk); #2 dst_rst_n = 1'b1;
        @(negedge src_clk);
        check(!src_busy, "R1", "busy after reset", DW'(src_busy), DW'(0));
        @(negedge dst_clk);
        check(!dst_valid, "R1", "valid after reset", DW'(dst_valid), DW'(0));
        check(dst_data == '0, "R1", "data after reset", dst_data, '0);
        run = 1;

        // Destination slower than source
        pattern_set();

        // Destination faster than source
        dst_half = 3;
        repeat (10) @(negedge src_clk);
        pattern_set();

        // R9: destination reset alone
        wait_idle();
        @(posedge dst_clk); #1 dst_rst_n = 1'b0;
        repeat (3) @(negedge dst_clk);
        check(dst_data == '0, "R9", "data under destination reset", dst_data, '0);
        check(!dst_valid, "R9", "valid under destination reset", DW'(dst_valid), DW'(0));
        check(!src_busy, "R9", "source idle during destination reset", DW'(src_busy), DW'(0));
        @(posedge dst_clk); #1 dst_rst_n = 1'b1;
        send(16'h3C3C);
        wait_idle();

        // R9: source reset alone
        kept = dst_data;
        @(posedge src_clk); #1 src_rst_n = 1'b0;
        repeat (4) @(negedge src_clk);
        check(!src_busy, "R9", "busy under source reset", DW'(src_busy), DW'(0));
        @(negedge dst_clk);
        check(dst_data == kept, "R9", "data kept over source reset", dst_data, kept);
        @(posedge src_clk); #1 src_rst_n = 1'b1;
        send(16'hBEEF);
        wait_idle();

        repeat (20) @(negedge src_clk);
        check(exp_q.size() == 0, "R6", "all accepted words delivered", DW'(exp_q.size()), DW'(0));
        check(ignored > 0, "R3", "strobes while busy exercised", DW'(ignored), DW'(1));
        finish_up();
    end
endmodule